// File: doc/BRIEF.md
# Packed/Scalar Floating-Point Minimum/Maximum Unit

This unit picks the smaller or the larger of two IEEE-754 operands in every lane of a 128-bit word. The lanes are either four single-precision values or two double-precision values. In packed mode every lane is computed. In scalar mode only lane 0 is computed, and every bit above it is copied from the first operand. The result is registered, so it appears one clock after the request.

NaN handling is deliberately lopsided. If either operand of a lane is a NaN, quiet or signaling, the lane raises its invalid flag and the second operand is what the lane produces. That operand is passed through bit for bit, with no quieting. Equal operands, including +0 against -0, also return the second operand. A per-operation mask bit decides what happens when an invalid flag is raised. With the mask set, the result is written normally. With the mask clear, the whole destination keeps its old value, no lane is reported written, and a fault is signalled. Every raised flag also sets a sticky status bit that only reset clears.

Top module: `fp_minmax`

## Requirements
- R1: `out_valid` goes high exactly one clock after a cycle with `in_valid` high, and is low otherwise. While `out_valid` is low, `lane_inv`, `lane_wr` and `fault` are all zero.
- R2: For non-NaN lanes, `op_is_max`=1 returns the larger operand and `op_is_max`=0 the smaller. The ordering is the real-number value, so negative values order below positive ones.
- R3: When neither operand is NaN and they compare equal, including +0 (all bits 0) against -0 (sign bit only), the second operand `src_b` is returned.
- R4: When the second operand is a NaN, the lane result is that operand, bit for bit, whatever the first operand is (including a NaN). A signaling NaN is not quieted.
- R5: When the first operand is a NaN and the second is not, the lane result is the second operand.
- R6: A NaN is an operand whose exponent field is all ones and whose fraction is nonzero, quiet or signaling. Any NaN in a computed lane sets that lane's bit in `lane_inv`: bit i for lane i, and for double lanes only bits 0 and 1.
- R7: With `inv_mask`=1, flagged lanes are written normally and `fault` stays 0.
- R8: With `inv_mask`=0 and any computed lane flagged, `fault` is 1, `lane_wr` is 0000 and `result` keeps its previous value.
- R9: Packed mode (`scalar_sel`=0) uses single lanes in bits [32i+31:32i] when `dbl_sel`=0, and double lanes in bits [64i+63:64i] when `dbl_sel`=1. `lane_wr` is 1111 for a non-faulting packed operation.
- R10: Scalar mode (`scalar_sel`=1) computes lane 0 only and copies every bit above it from `src_a`. NaNs in the upper lanes raise no flag. `lane_wr` is 0001 for single and 0011 for double (one bit per 32-bit slot).
- R11: `sticky_inv` is set by any accepted operation that has a flagged lane, whether masked or not. It stays set until reset.
- R12: After reset, `out_valid`, `result`, `lane_inv`, `lane_wr`, `fault` and `sticky_inv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_is_max | input | 1 | 1 = maximum, 0 = minimum |
| dbl_sel | input | 1 | 1 = double lanes, 0 = single lanes |
| scalar_sel | input | 1 | 1 = lane 0 only, upper bits from src_a |
| inv_mask | input | 1 | 1 = invalid masked (write result), 0 = fault |
| src_a | input | 128 | First operand word |
| src_b | input | 128 | Second operand word |
| out_valid | output | 1 | Result cycle of an accepted operation |
| result | output | 128 | Destination value |
| lane_inv | output | 4 | Per-lane invalid flags |
| lane_wr | output | 4 | 32-bit slots written by this operation |
| fault | output | 1 | Unmasked invalid: destination not updated |
| sticky_inv | output | 1 | Accumulated invalid status |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:
- +0 against -0 in both directions. A design that orders by the raw bit pattern would return the first operand.
- Negative pairs. A design that compares magnitudes only would pick the wrong one.
- NaN in the first position only. The result must be the second operand, not the NaN.
- Signaling NaN in the second position. A design that quiets it would set the fraction's top bit.
- Scalar operations with NaNs only in the upper lanes. A design that flags or computes all lanes would fault or overwrite the copied bits.
- Unmasked faults. A design that writes the destination anyway would lose the held value.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int SGL_W = 32;
  localparam int DBL_W = 64;
  localparam int SLOT_W = SGL_W;

  // exponent field width for a lane width
  function automatic int exp_width(input int w);
    return (w == DBL_W) ? 11 : 8;
  endfunction
endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane
  import fpmm_pkg::*;
#(
  parameter int W = SGL_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         want_max,
  output logic [W-1:0] pick,
  output logic         invalid
);
  localparam int EW = exp_width(W);
  localparam int FW = W - 1 - EW;

  function automatic logic is_nan(input logic [W-1:0] v);
    return (&v[W-2:FW]) && (|v[FW-1:0]);
  endfunction

  // strict real-value ordering of two non-NaN encodings, zeros equal
  function automatic logic below(input logic [W-1:0] x, input logic [W-1:0] y);
    if (!(|x[W-2:0]) && !(|y[W-2:0])) return 1'b0;
    if (x[W-1] != y[W-1]) return x[W-1];
    if (!x[W-1]) return x[W-2:0] < y[W-2:0];
    return x[W-2:0] > y[W-2:0];
  endfunction

  logic nan_a, nan_b;

  always_comb begin
    nan_a   = is_nan(opa);
    nan_b   = is_nan(opb);
    invalid = nan_a | nan_b;
    if (invalid)       pick = opb;
    else if (want_max) pick = below(opb, opa) ? opa : opb;
    else               pick = below(opa, opb) ? opa : opb;
  end
endmodule

// File: rtl/fpmm_datapath.sv
module fpmm_datapath
  import fpmm_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic                 want_max,
  input  logic                 dbl,
  input  logic                 scalar,
  output logic [DW-1:0]        nxt_res,
  output logic [DW/SGL_W-1:0]  nxt_inv,
  output logic [DW/SGL_W-1:0]  nxt_wr
);
  localparam int NS = DW / SGL_W;
  localparam int ND = DW / DBL_W;

  logic [NS-1:0][SGL_W-1:0] s_pick;
  logic [NS-1:0]            s_inv;
  logic [ND-1:0][DBL_W-1:0] d_pick;
  logic [ND-1:0]            d_inv;

  for (genvar gs = 0; gs < NS; gs++) begin : g_sgl
    fpmm_lane #(.W(SGL_W)) u_lane (
      .opa(a[SGL_W*gs +: SGL_W]), .opb(b[SGL_W*gs +: SGL_W]),
      .want_max(want_max), .pick(s_pick[gs]), .invalid(s_inv[gs])
    );
  end

  for (genvar gd = 0; gd < ND; gd++) begin : g_dbl
    fpmm_lane #(.W(DBL_W)) u_lane (
      .opa(a[DBL_W*gd +: DBL_W]), .opb(b[DBL_W*gd +: DBL_W]),
      .want_max(want_max), .pick(d_pick[gd]), .invalid(d_inv[gd])
    );
  end

  always_comb begin
    nxt_res = a;
    nxt_inv = '0;
    nxt_wr  = '0;
    if (scalar) begin
      if (dbl) begin
        nxt_res[DBL_W-1:0] = d_pick[0];
        nxt_inv[0]         = d_inv[0];
        nxt_wr[1:0]        = 2'b11;
      end else begin
        nxt_res[SGL_W-1:0] = s_pick[0];
        nxt_inv[0]         = s_inv[0];
        nxt_wr[0]          = 1'b1;
      end
    end else begin
      nxt_wr = '1;
      if (dbl) begin
        nxt_res          = d_pick;
        nxt_inv[ND-1:0]  = d_inv;
      end else begin
        nxt_res = s_pick;
        nxt_inv = s_inv;
      end
    end
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax
  import fpmm_pkg::*;
#(
  parameter int DW = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 op_is_max,
  input  logic                 dbl_sel,
  input  logic                 scalar_sel,
  input  logic                 inv_mask,
  input  logic [DW-1:0]        src_a,
  input  logic [DW-1:0]        src_b,
  output logic                 out_valid,
  output logic [DW-1:0]        result,
  output logic [DW/32-1:0]     lane_inv,
  output logic [DW/32-1:0]     lane_wr,
  output logic                 fault,
  output logic                 sticky_inv
);
  localparam int NS = DW / SGL_W;

  logic [DW-1:0] dp_res;
  logic [NS-1:0] dp_inv;
  logic [NS-1:0] dp_wr;
  logic          op_fault;

  fpmm_datapath #(.DW(DW)) u_dp (
    .a(src_a), .b(src_b), .want_max(op_is_max), .dbl(dbl_sel),
    .scalar(scalar_sel), .nxt_res(dp_res), .nxt_inv(dp_inv), .nxt_wr(dp_wr)
  );

  assign op_fault = in_valid && !inv_mask && (|dp_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      lane_inv   <= '0;
      lane_wr    <= '0;
      fault      <= 1'b0;
      sticky_inv <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lane_inv   <= dp_inv;
        fault      <= op_fault;
        lane_wr    <= op_fault ? '0 : dp_wr;
        sticky_inv <= sticky_inv | (|dp_inv);
        if (!op_fault) result <= dp_res;
      end else begin
        lane_inv <= '0;
        fault    <= 1'b0;
        lane_wr  <= '0;
      end
    end
  end
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk #(
  parameter int DW = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            dbl_sel,
  input logic            scalar_sel,
  input logic            inv_mask,
  input logic [DW-1:0]   src_a,
  input logic            out_valid,
  input logic [DW-1:0]   result,
  input logic [DW/32-1:0] lane_inv,
  input logic [DW/32-1:0] lane_wr,
  input logic            fault,
  input logic            sticky_inv
);
  localparam int NS = DW / 32;
  localparam int ND = DW / 64;

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (lane_inv == '0 && lane_wr == '0 && !fault)); // R1
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> lane_wr == '0); // R8
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) fault |-> result == $past(result)); // R8
  AST_FAULT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) fault |-> lane_inv != '0); // R6
  AST_MASKED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && inv_mask) |=> !fault); // R7
  AST_DBL_UPPER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && dbl_sel) |=> lane_inv[NS-1:ND] == '0); // R9
  AST_SCALAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && scalar_sel && inv_mask) |=> result[DW-1:64] == $past(src_a[DW-1:64])); // R10
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !$fell(sticky_inv)); // R11
  AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (|lane_inv) |-> sticky_inv); // R11
endmodule

bind fp_minmax fp_minmax_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dbl_sel(dbl_sel),
  .scalar_sel(scalar_sel), .inv_mask(inv_mask), .src_a(src_a),
  .out_valid(out_valid), .result(result), .lane_inv(lane_inv),
  .lane_wr(lane_wr), .fault(fault), .sticky_inv(sticky_inv)
);

// File: tb/fp_minmax_bench.sv
module fp_minmax_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, op_is_max = 1'b0, dbl_sel = 1'b0, scalar_sel = 1'b0, inv_mask = 1'b1;
  logic [127:0] src_a = '0, src_b = '0;
  logic out_valid, fault, sticky_inv;
  logic [127:0] result;
  logic [3:0] lane_inv, lane_wr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [127:0] e_res = '0;
  logic [3:0]   e_inv = '0, e_wr = '0;
  logic         e_ov = 0, e_flt = 0, e_sticky = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax u_fp_minmax (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_is_max(op_is_max),
    .dbl_sel(dbl_sel), .scalar_sel(scalar_sel), .inv_mask(inv_mask),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .lane_inv(lane_inv), .lane_wr(lane_wr), .fault(fault), .sticky_inv(sticky_inv)
  );

  // single constants
  localparam logic [31:0] S_ONE = 32'h3F800000, S_TWO = 32'h40000000, S_M1 = 32'hBF800000,
    S_M2 = 32'hC0000000, S_PZ = 32'h00000000, S_NZ = 32'h80000000,
    S_QN = 32'h7FC00000, S_SN = 32'h7FA00000, S_QN2 = 32'hFFC12345;
  // double constants
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000,
    D_M1 = 64'hBFF0000000000000, D_M3 = 64'hC008000000000000, D_PZ = 64'h0,
    D_NZ = 64'h8000000000000000, D_QN = 64'h7FF8000000000000, D_SN = 64'h7FF4000000000001;

  function automatic bit nan32(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit nan64(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic real val32(input logic [31:0] x);
    logic [63:0] w;
    if (x[30:23] == 0) return 0.0;
    w = {x[31], 11'(int'(x[30:23]) + 896), x[22:0], 29'b0};
    return $bitstoreal(w);
  endfunction
  function automatic logic [31:0] ref32(input logic [31:0] a, b, input bit mx);
    if (nan32(a) || nan32(b)) return b;
    if (mx) return (val32(a) > val32(b)) ? a : b;
    return (val32(a) < val32(b)) ? a : b;
  endfunction
  function automatic logic [63:0] ref64(input logic [63:0] a, b, input bit mx);
    if (nan64(a) || nan64(b)) return b;
    if (mx) return ($bitstoreal(a) > $bitstoreal(b)) ? a : b;
    return ($bitstoreal(a) < $bitstoreal(b)) ? a : b;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk("R1 out_valid", 128'(out_valid), 128'(e_ov));
    chk({tag, " result"}, result, e_res);
    chk({tag, " lane_inv R6"}, 128'(lane_inv), 128'(e_inv));
    chk({tag, " lane_wr"}, 128'(lane_wr), 128'(e_wr));
    chk("R8 fault", 128'(fault), 128'(e_flt));
    chk("R11 sticky", 128'(sticky_inv), 128'(e_sticky));
  endtask

  task automatic step(input bit v, input logic [127:0] a, b, input bit mx, dbl, sc, msk,
                      input string tag);
    logic [127:0] nres;
    logic [3:0] ninv, nwr;
    int n;
    in_valid = v; src_a = a; src_b = b; op_is_max = mx; dbl_sel = dbl;
    scalar_sel = sc; inv_mask = msk;
    e_ov = v;
    if (v) begin
      nres = sc ? a : '0;
      ninv = '0;
      n = sc ? 1 : (dbl ? 2 : 4);
      for (int k = 0; k < n; k++) begin
        if (dbl) begin
          nres[64*k +: 64] = ref64(a[64*k +: 64], b[64*k +: 64], mx);
          ninv[k] = nan64(a[64*k +: 64]) || nan64(b[64*k +: 64]);
        end else begin
          nres[32*k +: 32] = ref32(a[32*k +: 32], b[32*k +: 32], mx);
          ninv[k] = nan32(a[32*k +: 32]) || nan32(b[32*k +: 32]);
        end
      end
      nwr = sc ? (dbl ? 4'b0011 : 4'b0001) : 4'b1111;
      e_inv = ninv;
      e_flt = !msk && (ninv != 0);
      e_wr = e_flt ? 4'b0 : nwr;
      if (!e_flt) e_res = nres;
      e_sticky = e_sticky | (ninv != 0);
    end else begin
      e_inv = '0; e_wr = '0; e_flt = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] pick_s(input int i);
    case (i % 9)
      0: return S_ONE; 1: return S_TWO; 2: return S_M1; 3: return S_M2; 4: return S_PZ;
      5: return S_NZ; 6: return S_QN; 7: return S_SN; default: return S_QN2;
    endcase
  endfunction
  function automatic logic [63:0] pick_d(input int i);
    case (i % 8)
      0: return D_ONE; 1: return D_TWO; 2: return D_M1; 3: return D_M3;
      4: return D_PZ; 5: return D_NZ; 6: return D_QN; default: return D_SN;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    compare("R12");
    rst_n = 1'b1;
    step(0, '0, '0, 0, 0, 0, 1, "R12");
    // R2 R3 packed single min then max, +0/-0 pair in lane 3
    step(1, {S_PZ, S_TWO, S_M1, S_ONE}, {S_NZ, S_ONE, S_M2, S_TWO}, 0, 0, 0, 1, "R2 R3 R9");
    step(1, {S_PZ, S_TWO, S_M1, S_ONE}, {S_NZ, S_ONE, S_M2, S_TWO}, 1, 0, 0, 1, "R2 R3 R9");
    step(1, {S_NZ, S_M2, S_TWO, S_ONE}, {S_PZ, S_M1, S_TWO, S_M2}, 0, 0, 0, 1, "R3");
    // packed double
    step(1, {D_M1, D_NZ}, {D_M3, D_PZ}, 0, 1, 0, 1, "R2 R3 R9");
    step(1, {D_M1, D_TWO}, {D_M3, D_ONE}, 1, 1, 0, 1, "R2 R9");
    step(0, '0, '0, 0, 0, 0, 1, "R1");
    // NaN rules masked
    step(1, {S_QN2, S_SN, S_ONE, S_QN}, {S_SN, S_TWO, S_QN, S_ONE}, 0, 0, 0, 1, "R4 R5 R7");
    step(1, {S_QN, S_ONE, S_ONE, S_SN}, {S_QN2, S_SN, S_TWO, S_M1}, 1, 0, 0, 1, "R4 R5 R6");
    step(1, {D_QN, D_ONE}, {D_SN, D_QN}, 1, 1, 0, 1, "R4 R6");
    // unmasked fault holds destination
    step(1, {S_ONE, S_ONE, S_ONE, S_QN}, {S_TWO, S_TWO, S_TWO, S_TWO}, 0, 0, 0, 0, "R8");
    step(1, {D_SN, D_ONE}, {D_TWO, D_M1}, 1, 1, 0, 0, "R8");
    step(1, {S_ONE, S_M1, S_M2, S_TWO}, {S_TWO, S_M2, S_M1, S_ONE}, 1, 0, 0, 0, "R8 R2");
    // scalar with NaNs only in upper lanes, unmasked
    step(1, {S_QN, S_SN, S_QN2, S_M1}, {S_SN, S_QN, S_ONE, S_M2}, 0, 0, 1, 0, "R10");
    step(1, {D_QN, D_M1}, {D_SN, D_M3}, 1, 1, 1, 0, "R10");
    step(1, {D_QN, D_SN}, {D_ONE, D_ONE}, 1, 1, 1, 0, "R10 R8");
    step(1, {S_TWO, S_ONE, S_M1, S_QN}, {S_M1, S_M2, S_ONE, S_TWO}, 0, 0, 1, 1, "R10 R5");
    // mixed sweep
    for (int t = 0; t < 400; t++) begin
      logic [127:0] ra, rb;
      bit rd;
      rd = $urandom_range(0, 1);
      for (int k = 0; k < 4; k++) begin
        if (rd) begin
          if (k < 2) begin
            ra[64*k +: 64] = pick_d($urandom_range(0, 7));
            rb[64*k +: 64] = pick_d($urandom_range(0, 7));
          end
        end else begin
          ra[32*k +: 32] = pick_s($urandom_range(0, 8));
          rb[32*k +: 32] = pick_s($urandom_range(0, 8));
        end
      end
      step($urandom_range(0, 3) != 0, ra, rb, 1'($urandom_range(0, 1)), rd,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 R4 R5 R9 R10");
    end
    step(0, '0, '0, 0, 0, 0, 1, "R11");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule